// File: doc/BRIEF.md
# Serial Channel Register Front-End

This block is the processor-facing register layer of one serial channel. A simple register bus writes and reads byte-wide locations selected by a byte offset. Below the block sit a byte transmitter and a byte receiver, each reached through a valid/ready handshake. The block keeps the channel's status flags and its interrupt-status flags up to date as software touches the buffer locations and issues commands. It drives one interrupt line that is high whenever an interrupt-status bit is set and the matching mask bit is also set.

The serial shifter and the bit-rate generator are not part of this block. The two rate bytes are only held here for software to read back. Read data is combinational from the current state. A read with a side effect, such as clearing the interrupt status or consuming the received byte, takes effect at the clock edge that ends the access.

Top module: `uart_regfront`

## Requirements
- R1: After reset, the status location (offset 0x04) reads 0x0C when `tx_ready` is high. The interrupt-status location (offset 0x14) reads 0x00, `irq` is low, `tx_valid` is low and `rx_ready` is low.
- R2: The mode byte (offset 0x00), the upper rate byte (offset 0x18) and the lower rate byte (offset 0x1C) read back the last value written to them.
- R3: A write to the command location (offset 0x08) decodes two enable fields, where code 01 enables and code 10 disables. Bits [1:0] control the receiver, which drives `rx_ready`. Bits [3:2] control the transmitter. Enabling the transmitter sets status bits 2 (transmit ready) and 3 (transmit empty). Disabling it clears both bits.
- R4: A command write with bits [6:4] equal to 4 clears status bits [7:4]. Status bit 4 is the overrun flag.
- R5: A write to the buffer location (offset 0x0C) presents its byte on `tx_data` with `tx_valid` high, while the transmitter is enabled, until exactly one transfer completes. It also sets status bits 2 and 3 and interrupt-status bit 0.
- R6: Status bit 2 reads as 1 only while its flag is set and `tx_ready` is high.
- R7: An accepted receive byte is stored in the receive buffer. It sets status bit 0 (receive ready) and interrupt-status bit 1.
- R8: A byte that arrives while status bit 0 is still set replaces the stored byte and sets status bits 1 (full) and 4 (overrun).
- R9: A read of the buffer location returns the received byte and clears status bits 0 and 1 and interrupt-status bit 1. If a byte arrives in the same cycle, that byte is stored, status bit 0 stays set, no overrun is flagged, and interrupt-status bit 1 stays set.
- R10: A read of offset 0x14 returns the interrupt status and then clears it to 0. A bit set by an event in the same cycle survives the clear.
- R11: A write to offset 0x14 sets the interrupt mask. `irq` is high exactly when the mask and the interrupt status share a set bit.
- R12: A write to offset 0x04 (clock select) has no effect on the status read at that offset. Offset 0x08 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Transmitter accepts / is ready |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Receiver enabled, byte accepted |
| rx_data | input | 8 | Receive byte |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest cases to reach are the same-cycle collisions. One is a receive byte landing in the very cycle that software reads the buffer. The other is a byte landing in the cycle that software reads the interrupt status. In both cases, one path clears a flag while another path sets it. The stimulus raises `rx_valid` and starts a bus read on the same falling edge and holds both for exactly one rising edge. The follow-up reads then show which event won. For the transmit side, `tx_ready` is held low across several cycles so that the held byte and the single-transfer count can be observed.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int OFS_W  = 6;
  localparam int BYTE_W = 8;

  localparam logic [OFS_W-1:0] OFS_MODE  = 6'h00;
  localparam logic [OFS_W-1:0] OFS_STAT  = 6'h04;
  localparam logic [OFS_W-1:0] OFS_CMD   = 6'h08;
  localparam logic [OFS_W-1:0] OFS_BUF   = 6'h0C;
  localparam logic [OFS_W-1:0] OFS_INT   = 6'h14;
  localparam logic [OFS_W-1:0] OFS_RATEH = 6'h18;
  localparam logic [OFS_W-1:0] OFS_RATEL = 6'h1C;

  localparam int ST_RXRDY = 0;
  localparam int ST_FULL  = 1;
  localparam int ST_TXRDY = 2;
  localparam int ST_TXEMP = 3;
  localparam int ST_OVR   = 4;
  localparam int IS_TX    = 0;
  localparam int IS_RX    = 1;

  localparam logic [BYTE_W-1:0] STAT_RST = 8'h0C;

  typedef enum logic [1:0] {
    EN_KEEP0 = 2'b00,
    EN_ON    = 2'b01,
    EN_OFF   = 2'b10,
    EN_KEEP3 = 2'b11
  } en_code_e;

  function automatic logic err_clear_cmd(input logic [2:0] misc);
    return misc == 3'd4;
  endfunction

  function automatic logic [BYTE_W-1:0] stat_view(input logic [BYTE_W-1:0] flags,
                                                  input logic ready);
    logic [BYTE_W-1:0] v;
    v = flags;
    v[ST_TXRDY] = flags[ST_TXRDY] & ready;
    return v;
  endfunction

  function automatic logic irq_any(input logic [BYTE_W-1:0] mask,
                                   input logic [BYTE_W-1:0] pend);
    return |(mask & pend);
  endfunction
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = OFS_W
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              wr_mode,
  output logic              wr_cmd,
  output logic              wr_tx,
  output logic              wr_mask,
  output logic              wr_rateh,
  output logic              wr_ratel,
  output logic              rd_rx,
  output logic              rd_int
);
  logic wr, rd;
  assign wr = bus_en & bus_we;
  assign rd = bus_en & ~bus_we;

  assign wr_mode  = wr && bus_addr == ADDR_W'(OFS_MODE);
  assign wr_cmd   = wr && bus_addr == ADDR_W'(OFS_CMD);
  assign wr_tx    = wr && bus_addr == ADDR_W'(OFS_BUF);
  assign wr_mask  = wr && bus_addr == ADDR_W'(OFS_INT);
  assign wr_rateh = wr && bus_addr == ADDR_W'(OFS_RATEH);
  assign wr_ratel = wr && bus_addr == ADDR_W'(OFS_RATEL);
  assign rd_rx    = rd && bus_addr == ADDR_W'(OFS_BUF);
  assign rd_int   = rd && bus_addr == ADDR_W'(OFS_INT);
endmodule

// File: rtl/uart_rf_txpath.sv
module uart_rf_txpath #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              tx_en,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_hold
);
  logic accept;
  assign tx_valid = tx_hold & tx_en;
  assign accept   = tx_valid & tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold <= 1'b0;
      tx_data <= '0;
    end else begin
      if (load) begin
        tx_hold <= 1'b1;
        tx_data <= load_data;
      end else if (accept) begin
        tx_hold <= 1'b0;
      end
    end
  end

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !load) |=> (tx_hold && $stable(tx_data)));

  // R5
  tx_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !load) |=> !tx_valid);
endmodule

// File: rtl/uart_rf_status.sv
module uart_rf_status
  import uart_rf_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic [6:0]        cmd_fld,
  input  logic              wr_tx,
  input  logic              rd_rx,
  input  logic              rd_int,
  input  logic              rx_take,
  input  logic [DATA_W-1:0] rx_byte,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] int_q,
  output logic [DATA_W-1:0] rx_buf_q,
  output logic              rx_en,
  output logic              tx_en
);
  en_code_e rx_code, tx_code;
  logic     err_clr, overrun_ev;
  logic [DATA_W-1:0] stat_d, int_d;

  assign rx_code    = en_code_e'(cmd_fld[1:0]);
  assign tx_code    = en_code_e'(cmd_fld[3:2]);
  assign err_clr    = wr_cmd & err_clear_cmd(cmd_fld[6:4]);
  assign overrun_ev = rx_take & stat_q[ST_RXRDY] & ~rd_rx;

  always_comb begin
    stat_d = stat_q;
    if (wr_cmd && tx_code == EN_ON) begin
      stat_d[ST_TXRDY] = 1'b1;
      stat_d[ST_TXEMP] = 1'b1;
    end
    if (wr_cmd && tx_code == EN_OFF) begin
      stat_d[ST_TXRDY] = 1'b0;
      stat_d[ST_TXEMP] = 1'b0;
    end
    if (err_clr) stat_d[7:4] = '0;
    if (wr_tx) begin
      stat_d[ST_TXRDY] = 1'b1;
      stat_d[ST_TXEMP] = 1'b1;
    end
    if (rd_rx) begin
      stat_d[ST_RXRDY] = 1'b0;
      stat_d[ST_FULL]  = 1'b0;
    end
    if (rx_take) stat_d[ST_RXRDY] = 1'b1;
    if (overrun_ev) begin
      stat_d[ST_FULL] = 1'b1;
      stat_d[ST_OVR]  = 1'b1;
    end
  end

  always_comb begin
    int_d = int_q;
    if (rd_int) int_d = '0;
    if (rd_rx) int_d[IS_RX] = 1'b0;
    if (wr_tx) int_d[IS_TX] = 1'b1;
    if (rx_take) int_d[IS_RX] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q   <= STAT_RST;
      int_q    <= '0;
      rx_buf_q <= '0;
      rx_en    <= 1'b0;
      tx_en    <= 1'b0;
    end else begin
      stat_q <= stat_d;
      int_q  <= int_d;
      if (rx_take) rx_buf_q <= rx_byte;
      if (wr_cmd && rx_code == EN_ON)  rx_en <= 1'b1;
      if (wr_cmd && rx_code == EN_OFF) rx_en <= 1'b0;
      if (wr_cmd && tx_code == EN_ON)  tx_en <= 1'b1;
      if (wr_cmd && tx_code == EN_OFF) tx_en <= 1'b0;
    end
  end

  // R4
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !rx_take) |=> (stat_q[7:4] == '0));

  // R8
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_ev |=> (stat_q[ST_OVR] && stat_q[ST_FULL] && stat_q[ST_RXRDY]));

  // R10
  int_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_int && !rx_take && !wr_tx) |=> (int_q == '0));

  // R3
  tx_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && tx_code == EN_ON) |=> (stat_q[ST_TXEMP] && stat_q[ST_TXRDY] && tx_en));

  // R7
  rx_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take |=> (stat_q[ST_RXRDY] && int_q[IS_RX]));
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = OFS_W,
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              irq
);
  logic wr_mode, wr_cmd, wr_tx, wr_mask, wr_rateh, wr_ratel, rd_rx, rd_int;
  logic rx_take, rx_en, tx_en, tx_hold;
  logic [DATA_W-1:0] stat_q, int_q, rx_buf_q;
  logic [DATA_W-1:0] mode_q, mask_q, rateh_q, ratel_q;

  uart_rf_decode #(.ADDR_W(ADDR_W)) dec_i (
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .wr_mode(wr_mode), .wr_cmd(wr_cmd), .wr_tx(wr_tx), .wr_mask(wr_mask),
    .wr_rateh(wr_rateh), .wr_ratel(wr_ratel), .rd_rx(rd_rx), .rd_int(rd_int)
  );

  assign rx_ready = rx_en;
  assign rx_take  = rx_valid & rx_en;

  uart_rf_status #(.DATA_W(DATA_W)) st_i (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .cmd_fld(bus_wdata[6:0]),
    .wr_tx(wr_tx), .rd_rx(rd_rx), .rd_int(rd_int), .rx_take(rx_take),
    .rx_byte(rx_data), .stat_q(stat_q), .int_q(int_q), .rx_buf_q(rx_buf_q),
    .rx_en(rx_en), .tx_en(tx_en)
  );

  uart_rf_txpath #(.DATA_W(DATA_W)) tx_i (
    .clk(clk), .rst_n(rst_n), .load(wr_tx), .load_data(bus_wdata),
    .tx_en(tx_en), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_hold(tx_hold)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      mask_q  <= '0;
      rateh_q <= '0;
      ratel_q <= '0;
    end else begin
      if (wr_mode)  mode_q  <= bus_wdata;
      if (wr_mask)  mask_q  <= bus_wdata;
      if (wr_rateh) rateh_q <= bus_wdata;
      if (wr_ratel) ratel_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_W'(OFS_MODE):  bus_rdata = mode_q;
      ADDR_W'(OFS_STAT):  bus_rdata = stat_view(stat_q, tx_ready);
      ADDR_W'(OFS_BUF):   bus_rdata = rx_buf_q;
      ADDR_W'(OFS_INT):   bus_rdata = int_q;
      ADDR_W'(OFS_RATEH): bus_rdata = rateh_q;
      ADDR_W'(OFS_RATEL): bus_rdata = ratel_q;
      default:            bus_rdata = '0;
    endcase
  end

  assign irq = irq_any(mask_q, int_q);

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (int_q != '0 && mask_q != '0));

  // R5
  tx_load_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx |=> (tx_hold && int_q[IS_TX] && stat_q[ST_TXEMP]));
endmodule

// File: tb/uart_regfront_tb.sv
`timescale 1ns/1ps
module uart_regfront_tb_top;
  localparam real CYC = 20.0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 0, bus_we = 0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, tx_data, rx_data = '0;
  logic tx_valid, tx_ready = 1'b1, rx_valid = 1'b0, rx_ready, irq;

  int n_tests = 0, n_fail = 0, tx_acc = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CYC/2) clk = ~clk;

  uart_regfront dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .irq(irq)
  );

  always @(posedge clk) if (tx_valid && tx_ready) tx_acc <= tx_acc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read data while a read is on the bus
  initial forever begin
    @(negedge clk); #2;
    if (bus_en && !bus_we) begin
      if (exp_q.size() == 0) chk("scoreboard-empty", 1, 0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); bus_en = 0;
  endtask

  task automatic rx_byte(input logic [7:0] d);
    @(negedge clk); rx_valid = 1; rx_data = d;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CYC*100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rx_ready", rx_ready, 0);
    rd(6'h04, 8'h0C, "R1 status");
    rd(6'h14, 8'h00, "R1 int status");

    wr(6'h00, 8'hA5); wr(6'h18, 8'h3C); wr(6'h1C, 8'hC3);
    rd(6'h00, 8'hA5, "R2 mode");
    rd(6'h18, 8'h3C, "R2 rate high");
    rd(6'h1C, 8'hC3, "R2 rate low");

    wr(6'h04, 8'hFF);
    rd(6'h04, 8'h0C, "R12 clock select ignored");
    rd(6'h08, 8'h00, "R12 command reads zero");

    wr(6'h08, 8'h01); #1;
    chk("R3 rx enable", rx_ready, 1);
    wr(6'h08, 8'h08);
    rd(6'h04, 8'h00, "R3 tx disable clears 2,3");
    wr(6'h08, 8'h04);
    rd(6'h04, 8'h0C, "R3 tx enable sets 2,3");

    // transmit with a stalled transmitter
    tx_ready = 0;
    wr(6'h0C, 8'h5A); #1;
    chk("R5 tx_valid", tx_valid, 1);
    chk("R5 tx_data", tx_data, 8'h5A);
    rd(6'h04, 8'h08, "R6 tx ready hidden");
    #1;
    chk("R5 held valid", tx_valid, 1);
    chk("R5 held data", tx_data, 8'h5A);
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 1; #1;
    chk("R5 single transfer", tx_acc, 1);
    chk("R5 valid dropped", tx_valid, 0);
    rd(6'h04, 8'h0C, "R6 tx ready visible");
    rd(6'h14, 8'h01, "R5 int bit0");
    rd(6'h14, 8'h00, "R10 cleared by read");

    // mask and interrupt line
    wr(6'h14, 8'h01);
    wr(6'h0C, 8'h11); #1;
    chk("R11 irq tx", irq, 1);
    rd(6'h14, 8'h01, "R10 read tx int"); #1;
    chk("R11 irq drops", irq, 0);
    wr(6'h14, 8'h02);
    rx_byte(8'h77); #1;
    chk("R11 irq rx", irq, 1);
    rd(6'h04, 8'h0D, "R7 rx ready");
    rd(6'h0C, 8'h77, "R9 rx data"); #1;
    chk("R9 irq after rx read", irq, 0);
    rd(6'h04, 8'h0C, "R9 status cleared");
    rd(6'h14, 8'h00, "R9 int bit1 cleared");

    // overrun then error clear
    rx_byte(8'h10); rx_byte(8'h20);
    rd(6'h04, 8'h1F, "R8 overrun status");
    rd(6'h0C, 8'h20, "R8 newest byte");
    rd(6'h04, 8'h1C, "R9 keeps overrun");
    wr(6'h08, 8'h40);
    rd(6'h04, 8'h0C, "R4 error clear");
    rd(6'h14, 8'h00, "R9 int after reads");

    // arrival in the cycle of a buffer read
    rx_byte(8'h30);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = 6'h0C; rx_valid = 1; rx_data = 8'h31;
    exp_q.push_back(8'h30); tag_q.push_back("R9 collide read");
    @(negedge clk); bus_en = 0; rx_valid = 0;
    rd(6'h04, 8'h0D, "R9 collide no overrun");
    rd(6'h14, 8'h02, "R9 collide int kept");
    rd(6'h0C, 8'h31, "R9 collide new byte");

    // arrival in the cycle of an interrupt-status read
    wr(6'h0C, 8'h22);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = 6'h14; rx_valid = 1; rx_data = 8'h44;
    exp_q.push_back(8'h01); tag_q.push_back("R10 collide read");
    @(negedge clk); bus_en = 0; rx_valid = 0;
    rd(6'h14, 8'h02, "R10 event survives clear");
    rd(6'h0C, 8'h44, "R7 stored byte");

    wr(6'h08, 8'h02); #1;
    chk("R3 rx disable", rx_ready, 0);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule